// File: doc/BRIEF.md
# Sequential Multiply, Divide and Square-Root Unit

This block is a clocked arithmetic engine for signed two's-complement integers of `W` bits, with `W = 10` by default. It forms a product, a truncating quotient with remainder, or a floor square root with remainder. A host picks the operation with a 2-bit opcode when it pulses `start`. The unit then asks for its operands one at a time on a shared `data` bus. Each operand is requested by a strobe, `req_x` or `req_y`, and the host answers each request with a one-cycle `load` pulse. The `x` operand is the multiplicand, the divisor or the radicand. The `y` operand is the multiplier or the dividend. A root operation never asks for `y`.

One control FSM drives three iterative datapaths:
- a radix-2 Booth multiplier, which takes `W` steps;
- a restoring shift-subtract divider that works on magnitudes, which takes `W` steps;
- a two-bits-per-step square-root extractor, which takes `ceil(W/2)` steps.

The FSM states are:
- `ST_IDLE`: `ready` is high.
- `ST_GET_X`: `req_x` is high.
- `ST_GET_Y`: `req_y` is high.
- `ST_LAUNCH`: the operands are checked for errors and the selected datapath is started.
- `ST_RUN`: the FSM waits for the selected datapath's done pulse.

The FSM transitions are:
- `ST_IDLE`→`ST_GET_X` on `start` with a valid opcode.
- `ST_IDLE`→`ST_IDLE` on `start` with opcode 3, which is rejected.
- `ST_GET_X`→`ST_GET_Y` on `load` for multiply or divide.
- `ST_GET_X`→`ST_LAUNCH` on `load` for root.
- `ST_GET_Y`→`ST_LAUNCH` on `load`.
- `ST_LAUNCH`→`ST_IDLE` when an error is detected.
- `ST_LAUNCH`→`ST_RUN` otherwise.
- `ST_RUN`→`ST_IDLE` on the done pulse. On this edge `result`, `remainder` and `error` are written.

Top module: `mdr_unit`

## Requirements
- R1: After synchronous reset, `ready` is 1, and `req_x`, `req_y`, `error`, `result` and `remainder` are all 0.
- R2: A `start` in idle with opcode 0 (multiply), 1 (divide) or 2 (root) drops `ready` and raises `req_x` one cycle later. A `load` while `req_x` is high captures `x`. For multiply and divide, `req_y` follows, and a `load` captures `y`. For root, `req_y` is never raised.
- R3: A `load` pulse while neither request is active has no effect on the operands or on the outcome.
- R4: Multiply returns `x*y` when the product fits in `W` signed bits. Otherwise `result` is all ones. `remainder` is 0 in both cases.
- R5: Divide returns `y/x` truncated toward zero. The remainder carries the sign of the dividend, so `y = q*x + r`.
- R6: A quotient that does not fit in `W` signed bits (the most negative value divided by -1) gives `result` all ones and `remainder` 0.
- R7: Root of a non-negative `x` returns `floor(sqrt(x))`, and `remainder` is `x - root*root`.
- R8: A divisor of 0, or a negative radicand, sets `error` to 1 with `result` and `remainder` both 0.
- R9: `start` with opcode 3 is rejected. `error` is 1 one cycle later, `ready` stays 1, and no operand is requested.
- R10: `result`, `remainder` and `error` hold steady while the unit is idle, until the next `start`. An accepted `start` clears all three.
- R11: `req_x` and `req_y` are never high together, and neither is high while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled when `ready`) |
| op | input | 2 | Opcode: 0 multiply, 1 divide, 2 root |
| load | input | 1 | Operand strobe answering an active request |
| data | input | W | Shared operand bus, signed |
| result | output | W | Product, quotient or root; all ones on overflow |
| remainder | output | W | Division or root remainder, 0 for multiply |
| req_x | output | 1 | Unit is waiting for operand x |
| req_y | output | 1 | Unit is waiting for operand y |
| error | output | 1 | Divide by zero, negative radicand or bad opcode |
| ready | output | 1 | Unit is idle and accepts `start` |

## Verification
The hardest outcomes to reach are the narrow overflow edges. The most negative dividend divided by -1 is one such edge. Products just outside the signed range are another. Uniformly drawn operands land on these only a handful of times. The stimulus therefore adds directed cases at exactly these values, alongside a zero divisor, a radicand of -1, and both limits of the root range. It also issues a stray `load` carrying unrelated data while the datapath is running, to show that the pulse is not taken.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DIV  = 2'd1,
        OP_ROOT = 2'd2,
        OP_BAD  = 2'd3
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_X,
        ST_GET_Y,
        ST_LAUNCH,
        ST_RUN
    } state_e;

endpackage

// File: rtl/mdr_booth_mul.sv
module mdr_booth_mul #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         done,
    output logic [W-1:0] prod_lo,
    output logic         ovf
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    acc;
    logic [W:0]    mext;
    logic [W-1:0]  q;
    logic          qm1;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [W:0]    sum;

    // Booth recoding of the current bit pair
    always_comb begin
        unique case ({q[0], qm1})
            2'b01:   sum = acc + mext;
            2'b10:   sum = acc - mext;
            default: sum = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            mext <= '0;
            q    <= '0;
            qm1  <= 1'b0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                acc  <= '0;
                mext <= {mcand[W-1], mcand};
                q    <= mplier;
                qm1  <= 1'b0;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                // arithmetic shift right of {sum, q, qm1}
                acc <= {sum[W], sum[W:1]};
                q   <= {sum[0], q[W-1:1]};
                qm1 <= q[0];
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod_lo = q;
    // fits only if the whole upper part is a sign extension of q's MSB
    assign ovf     = |(acc ^ {(W + 1){q[W-1]}});

endmodule

// File: rtl/mdr_restore_div.sv
module mdr_restore_div #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  dmag;
    logic [W-1:0]  q;
    logic [W-1:0]  r;
    logic          neg_q;
    logic          neg_r;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [W:0]    rs;
    logic [W:0]    diff;
    logic          ge;

    always_comb begin
        rs   = {r, q[W-1]};
        diff = rs - {1'b0, dmag};
        ge   = ~diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dmag  <= '0;
            q     <= '0;
            r     <= '0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                dmag  <= divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
                q     <= dividend[W-1] ? (~dividend + 1'b1) : dividend;
                r     <= '0;
                neg_q <= dividend[W-1] ^ divisor[W-1];
                neg_r <= dividend[W-1];
                cnt   <= '0;
                busy  <= 1'b1;
            end else if (busy) begin
                r   <= ge ? diff[W-1:0] : rs[W-1:0];
                q   <= {q[W-2:0], ge};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = neg_q ? (~q + 1'b1) : q;
    assign rem = neg_r ? (~r + 1'b1) : r;
    assign ovf = ~neg_q & q[W-1];

endmodule

// File: rtl/mdr_sqrt_serial.sv
module mdr_sqrt_serial #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] radicand,
    output logic         done,
    output logic [W-1:0] root,
    output logic [W-1:0] rem
);
    localparam int WE = W + (W % 2);
    localparam int K  = WE / 2;
    localparam int CW = $clog2(K + 1);

    logic [WE-1:0] sh;
    logic [K-1:0]  rt;
    logic [K+1:0]  r;
    logic [K+1:0]  rs;
    logic [K+1:0]  trial;
    logic          ge;
    logic [CW-1:0] cnt;
    logic          busy;

    always_comb begin
        rs    = {r[K-1:0], sh[WE-1:WE-2]};
        trial = {rt, 2'b01};
        ge    = (rs >= trial);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            rt   <= '0;
            r    <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                sh   <= WE'(radicand);
                rt   <= '0;
                r    <= '0;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                r   <= ge ? (rs - trial) : rs;
                rt  <= {rt[K-2:0], ge};
                sh  <= {sh[WE-3:0], 2'b00};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(K - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign root = W'(rt);
    assign rem  = W'(r);

endmodule

// File: rtl/mdr_unit.sv
module mdr_unit
    import mdr_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic         load,
    input  logic [W-1:0] data,
    output logic [W-1:0] result,
    output logic [W-1:0] remainder,
    output logic         req_x,
    output logic         req_y,
    output logic         error,
    output logic         ready
);
    state_e  state, state_n;
    opcode_e op_q;
    logic [W-1:0] x_q, y_q;
    logic bad_now;

    logic         mul_go, mul_done, mul_ovf;
    logic [W-1:0] mul_p;
    logic         div_go, div_done, div_ovf;
    logic [W-1:0] div_q, div_r;
    logic         rt_go, rt_done;
    logic [W-1:0] rt_root, rt_rem;
    logic         unit_done;

    assign bad_now = ((op_q == OP_DIV)  && (x_q == '0)) ||
                     ((op_q == OP_ROOT) && x_q[W-1]);

    assign mul_go = (state == ST_LAUNCH) && (op_q == OP_MUL)  && !bad_now;
    assign div_go = (state == ST_LAUNCH) && (op_q == OP_DIV)  && !bad_now;
    assign rt_go  = (state == ST_LAUNCH) && (op_q == OP_ROOT) && !bad_now;

    always_comb begin
        unique case (op_q)
            OP_MUL:  unit_done = mul_done;
            OP_DIV:  unit_done = div_done;
            OP_ROOT: unit_done = rt_done;
            default: unit_done = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start && (opcode_e'(op) != OP_BAD)) state_n = ST_GET_X;
            ST_GET_X:  if (load) state_n = (op_q == OP_ROOT) ? ST_LAUNCH : ST_GET_Y;
            ST_GET_Y:  if (load) state_n = ST_LAUNCH;
            ST_LAUNCH: state_n = bad_now ? ST_IDLE : ST_RUN;
            ST_RUN:    if (unit_done) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        ready = (state == ST_IDLE);
        req_x = (state == ST_GET_X);
        req_y = (state == ST_GET_Y);
    end

    // operand capture and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= OP_MUL;
            x_q       <= '0;
            y_q       <= '0;
            result    <= '0;
            remainder <= '0;
            error     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    result    <= '0;
                    remainder <= '0;
                    error     <= (opcode_e'(op) == OP_BAD);
                    op_q      <= opcode_e'(op);
                end
                ST_GET_X: if (load) x_q <= data;
                ST_GET_Y: if (load) y_q <= data;
                ST_LAUNCH: if (bad_now) error <= 1'b1;
                ST_RUN: if (unit_done) begin
                    unique case (op_q)
                        OP_MUL: begin
                            result    <= mul_ovf ? '1 : mul_p;
                            remainder <= '0;
                        end
                        OP_DIV: begin
                            result    <= div_ovf ? '1 : div_q;
                            remainder <= div_ovf ? '0 : div_r;
                        end
                        default: begin
                            result    <= rt_root;
                            remainder <= rt_rem;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    mdr_booth_mul #(.W(W)) mul_i (
        .clk(clk), .rst(rst), .go(mul_go), .mcand(x_q), .mplier(y_q),
        .done(mul_done), .prod_lo(mul_p), .ovf(mul_ovf)
    );

    mdr_restore_div #(.W(W)) div_i (
        .clk(clk), .rst(rst), .go(div_go), .dividend(y_q), .divisor(x_q),
        .done(div_done), .quo(div_q), .rem(div_r), .ovf(div_ovf)
    );

    mdr_sqrt_serial #(.W(W)) rt_i (
        .clk(clk), .rst(rst), .go(rt_go), .radicand(x_q),
        .done(rt_done), .root(rt_root), .rem(rt_rem)
    );

endmodule

// File: rtl/mdr_unit_chk.sv
module mdr_unit_chk
    import mdr_pkg::*;
#(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [1:0]   op,
    input logic         ready,
    input logic         req_x,
    input logic         req_y,
    input logic         error,
    input logic [W-1:0] result,
    input logic [W-1:0] remainder,
    input opcode_e      op_q
);
    // R11
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_x && req_y));

    // R11
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!req_x && !req_y));

    // R2
    start_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start && op != 2'd3) |=> (!ready && req_x));

    // R2
    root_no_y_chk: assert property (@(posedge clk) disable iff (rst)
        req_y |-> (op_q != OP_ROOT));

    // R8
    error_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (result == '0 && remainder == '0));

    // R9
    bad_op_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start && op == 2'd3) |=> (ready && error && !req_x));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ($stable(result) && $stable(remainder) && $stable(error)));

endmodule

bind mdr_unit mdr_unit_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .ready(ready),
    .req_x(req_x), .req_y(req_y), .error(error), .result(result),
    .remainder(remainder), .op_q(op_q)
);

// File: tb/mdr_unit_tb_top.sv
module mdr_unit_tb_top;
    localparam int W = 10;
    localparam int MAXV = (1 << (W - 1)) - 1;
    localparam int MINV = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   op;
    logic         load;
    logic [W-1:0] data;
    logic [W-1:0] result, remainder;
    logic         req_x, req_y, error, ready;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic cur_root = 1'b0;

    always #2.5 clk = ~clk;

    mdr_unit #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .op(op), .load(load), .data(data),
        .result(result), .remainder(remainder), .req_x(req_x), .req_y(req_y),
        .error(error), .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // R2: root operations must never request y
    always @(negedge clk) begin
        if (!rst && cur_root && req_y) check(1'b0, "R2 req_y during root", 1, 0);
    end

    function automatic int sx(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int isqrt(input int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    task automatic model(input int o, input int x, input int y,
                         output logic [W-1:0] er, output logic [W-1:0] erem,
                         output logic eerr, output string tag);
        int p, q, rr;
        er = '0; erem = '0; eerr = 1'b0;
        if (o == 0) begin
            p = x * y;
            er = (p > MAXV || p < MINV) ? '1 : W'(p);
            tag = "R4 mul";
        end else if (o == 1) begin
            if (x == 0) begin
                eerr = 1'b1; tag = "R8 div0";
            end else begin
                q = y / x; rr = y % x;
                if (q > MAXV) begin
                    er = '1; tag = "R6 div ovf";
                end else begin
                    er = W'(q); erem = W'(rr); tag = "R5 div";
                end
            end
        end else begin
            if (x < 0) begin
                eerr = 1'b1; tag = "R8 root neg";
            end else begin
                rr = isqrt(x);
                er = W'(rr); erem = W'(x - rr * rr); tag = "R7 root";
            end
        end
    endtask

    task automatic run_op(input int o, input int x, input int y, input bit stray);
        logic [W-1:0] er, erem;
        logic eerr;
        string tag;
        model(o, x, y, er, erem, eerr, tag);
        while (!ready) @(negedge clk);
        cur_root = (o == 2);
        start = 1'b1; op = 2'(o);
        @(negedge clk);
        start = 1'b0;
        check(!ready && req_x, "R2 request x after start", {ready, req_x}, 1);
        check(error == 1'b0 && result == '0, "R10 start clears", int'(error), 0);
        while (!req_x) @(negedge clk);
        data = W'(x); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        if (o != 2) begin
            while (!req_y) @(negedge clk);
            data = W'(y); load = 1'b1;
            @(negedge clk);
            load = 1'b0;
        end
        if (stray) begin
            // R3: load with no request active must be ignored
            @(negedge clk);
            check(!req_x && !req_y, "R3 no request during run", {req_x, req_y}, 0);
            data = W'(x + 77); load = 1'b1;
            @(negedge clk);
            load = 1'b0;
        end
        while (!ready) @(negedge clk);
        cur_root = 1'b0;
        check(result == er,   {tag, " result"},    sx(result),    sx(er));
        check(remainder == erem, {tag, " remainder"}, sx(remainder), sx(erem));
        check(error == eerr,  {tag, " error"},     int'(error),   int'(eerr));
    endtask

    initial begin
        logic [W-1:0] hold_r, hold_m;
        void'($urandom(32'd5821));
        rst = 1'b1; start = 1'b0; op = '0; load = 1'b0; data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready && !req_x && !req_y && !error && result == '0 && remainder == '0,
              "R1 reset state", {ready, req_x, req_y, error}, 8);

        // R3: stray load while idle, then an operation still uses its own operands
        data = 10'd99; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(ready && !req_x, "R3 idle load ignored", int'(ready), 1);

        // directed corner cases
        run_op(0, -512, -1, 1'b0);   // R4 overflow
        run_op(0, 23, 23, 1'b1);     // R4 overflow
        run_op(0, 31, -16, 1'b0);    // R4 fits
        run_op(0, -512, 1, 1'b0);    // R4 most negative fits
        run_op(1, -1, -512, 1'b1);   // R6
        run_op(1, 1, -512, 1'b0);    // R5
        run_op(1, -2, 7, 1'b0);      // R5
        run_op(1, 2, -7, 1'b0);      // R5 negative remainder
        run_op(1, 0, 55, 1'b0);      // R8
        run_op(2, -1, 0, 1'b0);      // R8
        run_op(2, 0, 0, 1'b0);       // R7
        run_op(2, 1, 0, 1'b0);       // R7
        run_op(2, 511, 0, 1'b1);     // R7

        // R10: outputs hold while idle
        hold_r = result; hold_m = remainder;
        repeat (6) @(negedge clk);
        check(result == hold_r && remainder == hold_m, "R10 idle hold", sx(result), sx(hold_r));

        // R9: opcode 3 rejected
        start = 1'b1; op = 2'd3;
        @(negedge clk);
        start = 1'b0;
        check(error && ready && !req_x, "R9 bad opcode", {error, ready, req_x}, 6);
        @(negedge clk);
        check(!req_x && ready, "R9 no request", int'(req_x), 0);
        run_op(0, 3, 4, 1'b0);       // R10 error cleared by next start

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int o, x, y;
            o = int'($urandom % 3);
            x = sx(W'($urandom));
            y = sx(W'($urandom));
            if ($urandom % 16 == 0) x = 0;
            if (o == 0 && ($urandom % 2 == 1)) begin
                x = x % 40; y = y % 40;
            end
            run_op(o, x, y, ($urandom % 4) == 0);
        end

        finish_run();
    end

endmodule